// File: doc/BRIEF.md
# Timer Interrupt Vector and Priority Logic

This block gathers the interrupt events of a timer unit: input captures, output compares, counter overflow and pulse-accumulator events. Each event source owns a status flag and an enable bit. When any enabled flag is pending, the block drives one request at a level that software programs. When the processor acknowledges the request, the block returns an 8-bit vector. The upper nibble of that vector is a programmable base, and the lower nibble identifies the source that won.

Software may pick one source and promote it above all the others. While the promoted source wins, the lower vector nibble becomes 0. The other sources keep their fixed order and their own vector codes. A 4-bit arbitration value is compared against the values of a competing requester, so that the block can settle which side wins when both request at the same level.

Software reaches the block through a simple register bus with three registers: a configuration word, an enable mask and the flag register. Status flags follow a read-then-write-zero clear protocol.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: Register map: `bus_addr` 0 selects the 16-bit configuration word, 1 the enable mask and 2 the flag register. `bus_rdata` shows the selected register in the cycle after `bus_rd`. The configuration word is stored in full. Mask and flag bits at positions NSRC and above read as 0.
- R2: A 1 on `src_evt[k]` sets flag bit k at the next clock edge. Flag bit k belongs to the source whose vector index is k+1. For example, bit 3 maps to index 4 and bit 10 maps to index 0xB.
- R3: A flag bit clears only when a write of 0 to it follows a flag-register read that returned it as 1. A write of 0 without such a read leaves the flag set. A write of 1 has no effect. Any write to the flag register consumes the earlier read.
- R4: If an event sets a flag in the same cycle as a valid clear of that flag, the flag stays 1.
- R5: `irq_lvl` equals configuration bits [10:8] one cycle after any flag is set with its mask bit at 1. It is 0 when no such flag exists. A level field of 0 suppresses every request.
- R6: The vector is {configuration bits [7:4], index of the winner}. Among sources that are not promoted, the lowest index wins.
- R7: Configuration bits [15:12] name a promoted index from 1 to NSRC. When that source is pending and enabled, it wins over every other source and its vector low nibble is 0. The other sources keep their order and their indexes. A value of 0 or above NSRC promotes nothing.
- R8: A pulse on `iack` latches the vector. The latched vector appears on `vec_out` in the next cycle, together with a one-cycle `vec_valid`. `vec_out` then holds its value until the next `iack`, even when the flags change.
- R9: An acknowledge with no enabled pending source, or with level 0, returns low nibble 0xF.
- R10: `arb_win` is registered one cycle after its inputs. It is 1 only when a request is active and the arbitration value in configuration bits [3:0] is nonzero, and in addition either the programmed level is above `peer_lvl`, or the levels are equal and the arbitration value is above `peer_arb`.
- R11: After a synchronous reset, all registers, `irq_lvl`, `vec_out`, `vec_valid`, `arb_win` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| src_evt | input | NSRC | Per-source event pulses |
| iack | input | 1 | Interrupt acknowledge |
| peer_lvl | input | 3 | Level of the competing requester |
| peer_arb | input | 4 | Arbitration value of the competing requester |
| irq_lvl | output | 3 | Request level, 0 when idle |
| vec_out | output | 8 | Latched vector |
| vec_valid | output | 1 | One-cycle pulse after acknowledge |
| arb_win | output | 1 | This block wins the arbitration compare |

## Verification
A stale or stuck read-seen bit shows up as a flag that clears without a preceding read, or one that refuses to clear. The next flag-register read exposes it, two cycles after the write. A wrong priority or promotion decision changes the lower nibble of `vec_out` in the cycle after `iack`. A wrong enable or level state shows on `irq_lvl` one cycle after the event that should have raised it. Each of these reaches the ports within at most three cycles of its cause, so every scenario samples right after the responsible register stage.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int DW = 16;
  localparam int AW = 2;
  localparam logic [AW-1:0] ADDR_CFG  = 2'd0;
  localparam logic [AW-1:0] ADDR_MASK = 2'd1;
  localparam logic [AW-1:0] ADDR_FLAG = 2'd2;
  localparam logic [3:0] NIB_SPURIOUS = 4'hF;
  localparam logic [3:0] NIB_PROMOTED = 4'h0;

  typedef struct packed {
    logic [3:0] promo;
    logic       spare;
    logic [2:0] lvl;
    logic [3:0] base;
    logic [3:0] arb;
  } cfg_t;
endpackage

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic            rd_stb,
  input  logic            wr_stb,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] flags
);
  logic [NSRC-1:0] seen_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    logic clr_ok;
    assign clr_ok = wr_stb && !wdata[k] && seen_q[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        flags[k]  <= 1'b0;
        seen_q[k] <= 1'b0;
      end else begin
        if (evt[k])      flags[k] <= 1'b1;
        else if (clr_ok) flags[k] <= 1'b0;

        if (wr_stb)      seen_q[k] <= 1'b0;
        else if (rd_stb) seen_q[k] <= seen_q[k] | flags[k];
      end
    end
  end
endmodule

// File: rtl/tmr_irq_pick.sv
module tmr_irq_pick #(
  parameter int NSRC = 11
) (
  input  logic [NSRC-1:0] pend,
  input  logic [3:0]      promo,
  output logic            found,
  output logic [3:0]      nib
);
  import tmr_irq_pkg::*;

  logic       promo_ok;
  logic       promo_hit;
  logic [3:0] base_idx;

  assign promo_ok = (promo != 4'd0) && (int'(promo) <= NSRC);

  always_comb begin
    base_idx  = NIB_SPURIOUS;
    promo_hit = 1'b0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (pend[k]) base_idx = 4'(k + 1);
      if (promo_ok && (int'(promo) == k + 1) && pend[k]) promo_hit = 1'b1;
    end
  end

  assign found = |pend;
  assign nib   = promo_hit ? NIB_PROMOTED : base_idx;
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [2:0] my_lvl,
  input  logic [3:0] my_arb,
  input  logic [2:0] peer_lvl,
  input  logic [3:0] peer_arb,
  output logic       win
);
  logic lvl_above;
  logic tie_above;
  logic win_d;

  assign lvl_above = my_lvl > peer_lvl;
  assign tie_above = (my_lvl == peer_lvl) && (my_arb > peer_arb);
  assign win_d     = req && (my_arb != 4'd0) && (lvl_above || tie_above);

  always_ff @(posedge clk) begin
    if (rst) win <= 1'b0;
    else     win <= win_d;
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [15:0]     bus_wdata,
  output logic [15:0]     bus_rdata,
  input  logic [NSRC-1:0] src_evt,
  input  logic            iack,
  input  logic [2:0]      peer_lvl,
  input  logic [3:0]      peer_arb,
  output logic [2:0]      irq_lvl,
  output logic [7:0]      vec_out,
  output logic            vec_valid,
  output logic            arb_win
);
  import tmr_irq_pkg::*;

  localparam int MAX_SRC = 14;

  initial begin
    if (NSRC < 1 || NSRC > MAX_SRC) $error("NSRC must be 1..14");
  end

  cfg_t            cfg_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] pend;
  logic            req_on;
  logic            found;
  logic [3:0]      nib;
  logic            wr_cfg, wr_mask, wr_flag, rd_flag;

  assign wr_cfg  = bus_wr && (bus_addr == ADDR_CFG);
  assign wr_mask = bus_wr && (bus_addr == ADDR_MASK);
  assign wr_flag = bus_wr && (bus_addr == ADDR_FLAG);
  assign rd_flag = bus_rd && (bus_addr == ADDR_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= cfg_t'(bus_wdata);
      if (wr_mask) mask_q <= bus_wdata[NSRC-1:0];
    end
  end

  tmr_irq_flags #(.NSRC(NSRC)) flags_i (
    .clk    (clk),
    .rst    (rst),
    .evt    (src_evt),
    .rd_stb (rd_flag),
    .wr_stb (wr_flag),
    .wdata  (bus_wdata[NSRC-1:0]),
    .flags  (flag_q)
  );

  assign pend   = (cfg_q.lvl != 3'd0) ? (flag_q & mask_q) : '0;
  assign req_on = |pend;

  tmr_irq_pick #(.NSRC(NSRC)) pick_i (
    .pend  (pend),
    .promo (cfg_q.promo),
    .found (found),
    .nib   (nib)
  );

  tmr_irq_arb arb_i (
    .clk      (clk),
    .rst      (rst),
    .req      (req_on),
    .my_lvl   (cfg_q.lvl),
    .my_arb   (cfg_q.arb),
    .peer_lvl (peer_lvl),
    .peer_arb (peer_arb),
    .win      (arb_win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lvl   <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq_lvl   <= req_on ? cfg_q.lvl : 3'd0;
      vec_valid <= iack;
      if (iack) vec_out <= {cfg_q.base, found ? nib : NIB_SPURIOUS};
      if (bus_rd) begin
        case (bus_addr)
          ADDR_CFG:  bus_rdata <= 16'(cfg_q);
          ADDR_MASK: bus_rdata <= 16'(mask_q);
          ADDR_FLAG: bus_rdata <= 16'(flag_q);
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk #(
  parameter int NSRC = 11
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic            iack,
  input logic [2:0]      irq_lvl,
  input logic [7:0]      vec_out,
  input logic            vec_valid,
  input logic            arb_win,
  input logic [15:0]     cfg,
  input logic [NSRC-1:0] flags
);
  // R5
  lvl_match_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_lvl != 3'd0) |-> (irq_lvl == $past(cfg[10:8])));

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(iack) |-> $stable(vec_out));

  // R8
  vec_valid_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(iack));

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(flags) & ~flags)) |-> $past(bus_wr && bus_addr == 2'd2));

  // R7
  promo_nib_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && vec_out[3:0] == 4'h0) |-> ($past(cfg[15:12]) != 4'd0));

  // R10
  arb_zero_chk: assert property (@(posedge clk) disable iff (rst)
    arb_win |-> ($past(cfg[3:0]) != 4'd0));

  // R10
  arb_req_chk: assert property (@(posedge clk) disable iff (rst)
    arb_win |-> (irq_lvl != 3'd0));
endmodule

bind tmr_irq_ctrl tmr_irq_chk #(.NSRC(NSRC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .iack      (iack),
  .irq_lvl   (irq_lvl),
  .vec_out   (vec_out),
  .vec_valid (vec_valid),
  .arb_win   (arb_win),
  .cfg       (16'(cfg_q)),
  .flags     (flag_q)
);

// File: tb/tmr_irq_ctrl_tb.sv
module tmr_irq_ctrl_tb_top;
  localparam int NSRC = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]      bus_addr = '0;
  logic [15:0]     bus_wdata = '0;
  logic [15:0]     bus_rdata;
  logic [NSRC-1:0] src_evt = '0;
  logic            iack = 1'b0;
  logic [2:0]      peer_lvl = '0;
  logic [3:0]      peer_arb = '0;
  logic [2:0]      irq_lvl;
  logic [7:0]      vec_out;
  logic            vec_valid;
  logic            arb_win;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tmr_irq_ctrl #(.NSRC(NSRC)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_evt(src_evt), .iack(iack), .peer_lvl(peer_lvl), .peer_arb(peer_arb),
    .irq_lvl(irq_lvl), .vec_out(vec_out), .vec_valid(vec_valid), .arb_win(arb_win)
  );

  typedef struct packed {
    logic [15:0] cfg;
    logic [10:0] mask;
    logic [10:0] evt;
    logic [2:0]  lvl;
    logic [7:0]  vec;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{16'h0583, 11'h7FF, 11'h008, 3'd5, 8'h84},
    '{16'h0583, 11'h7FF, 11'h408, 3'd5, 8'h84},
    '{16'hB583, 11'h7FF, 11'h408, 3'd5, 8'h80},
    '{16'hB583, 11'h7FF, 11'h00C, 3'd5, 8'h83},
    '{16'h0783, 11'h3F7, 11'h408, 3'd0, 8'h8F},
    '{16'h0083, 11'h7FF, 11'h001, 3'd0, 8'h8F},
    '{16'h47A5, 11'h7FF, 11'h018, 3'd7, 8'hA0},
    '{16'h2321, 11'h7FF, 11'h7FE, 3'd3, 8'h20}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [NSRC-1:0] e);
    src_evt = e;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic do_iack();
    iack = 1'b1;
    @(negedge clk);
    iack = 1'b0;
  endtask

  task automatic clear_all();
    logic [15:0] d;
    bus_read(2'd2, d);
    bus_write(2'd2, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11 irq_lvl", 16'(irq_lvl), 16'h0);
    chk("R11 vec_out", 16'(vec_out), 16'h0);
    chk("R11 vec_valid/arb_win", {14'h0, vec_valid, arb_win}, 16'h0);
    bus_read(2'd0, d);
    chk("R11 cfg", d, 16'h0);

    // R1 register access
    bus_write(2'd0, 16'hB583);
    bus_read(2'd0, d);
    chk("R1 cfg readback", d, 16'hB583);
    bus_write(2'd1, 16'hFFFF);
    bus_read(2'd1, d);
    chk("R1 mask upper bits zero", d, 16'h07FF);

    // Table walk: R2 R5 R6 R7 R9 R8
    for (int i = 0; i < NROWS; i++) begin
      clear_all();
      bus_write(2'd0, ROWS[i].cfg);
      bus_write(2'd1, 16'(ROWS[i].mask));
      pulse_evt(ROWS[i].evt);
      @(negedge clk);
      chk($sformatf("R5 row %0d level", i), 16'(irq_lvl), 16'(ROWS[i].lvl));
      do_iack();
      chk($sformatf("R6/R7/R9 row %0d vector", i), 16'(vec_out), 16'(ROWS[i].vec));
      chk($sformatf("R8 row %0d valid", i), 16'(vec_valid), 16'h1);
    end

    // R3 clear protocol
    clear_all();
    bus_write(2'd0, 16'h0583);
    bus_write(2'd1, 16'h07FF);
    pulse_evt(11'h010);
    bus_write(2'd2, 16'h0000);
    bus_read(2'd2, d);
    chk("R3 write 0 without read keeps flag", d, 16'h0010);
    bus_write(2'd2, 16'h07FF);
    bus_read(2'd2, d);
    chk("R3 write 1 no effect", d, 16'h0010);
    bus_write(2'd2, 16'h0000);
    bus_read(2'd2, d);
    chk("R3 read then write 0 clears", d, 16'h0000);
    @(negedge clk);
    chk("R5 level drops after clear", 16'(irq_lvl), 16'h0);

    // R4 set wins over clear
    pulse_evt(11'h002);
    bus_read(2'd2, d);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h0000; src_evt = 11'h002;
    @(negedge clk);
    bus_wr = 1'b0; src_evt = '0;
    bus_read(2'd2, d);
    chk("R4 set beats clear", d, 16'h0002);

    // R8 latched vector
    @(negedge clk);
    do_iack();
    chk("R8 vector index 2", 16'(vec_out), 16'h0082);
    pulse_evt(11'h001);
    @(negedge clk);
    chk("R8 vector held", 16'(vec_out), 16'h0082);
    chk("R8 valid low without iack", 16'(vec_valid), 16'h0);
    do_iack();
    chk("R6 lower index wins", 16'(vec_out), 16'h0081);

    // R10 arbitration compare
    peer_lvl = 3'd5; peer_arb = 4'd2;
    @(negedge clk); @(negedge clk);
    chk("R10 same level higher arb wins", 16'(arb_win), 16'h1);
    peer_arb = 4'd4;
    @(negedge clk); @(negedge clk);
    chk("R10 same level lower arb loses", 16'(arb_win), 16'h0);
    peer_lvl = 3'd4; peer_arb = 4'hF;
    @(negedge clk); @(negedge clk);
    chk("R10 higher level wins", 16'(arb_win), 16'h1);
    peer_lvl = 3'd6; peer_arb = 4'h0;
    @(negedge clk); @(negedge clk);
    chk("R10 lower level loses", 16'(arb_win), 16'h0);
    bus_write(2'd0, 16'h0580);
    peer_lvl = 3'd5; peer_arb = 4'h0;
    @(negedge clk); @(negedge clk);
    chk("R10 zero arb never wins", 16'(arb_win), 16'h0);
    bus_write(2'd0, 16'h0583);
    clear_all();
    peer_lvl = 3'd0;
    @(negedge clk); @(negedge clk);
    chk("R10 no request no win", 16'(arb_win), 16'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule